// File: doc/BRIEF.md
# Parallel-Output PRBS Generator

This block produces a maximal-length pseudorandom bit stream for the polynomial x^31 + x^28 + 1, so the serial stream obeys y(n) = y(n-31) XOR y(n-28) and repeats every 2^31 - 1 bits. It does not shift one bit per clock. On each enabled clock it moves forward a full word of sequence positions, ten by default, and presents those bits together on a registered output word. This word feeds a wide-input serializer, so the logic runs at one tenth of the line rate. For example, a 150 MHz clock gives a 1.5 Gbps stream.

The polynomial order, the feedback tap and the word width are parameters. The same block therefore serves other test polynomials, such as x^7 + x^6 + 1 with period 127, or x^23 + x^18 + 1. When the word is no wider than the tap position, each new bit comes from one two-input XOR of bits already held in the register. A wider word selects a chained variant, which gives the same sequence with more logic depth. A synchronous reset loads a fixed non-zero seed. A seed-load input lets the user restart the sequence from any non-zero state.

Top module: `prbs_par_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the state loads the reset seed, which is all ones by default. The next output word is all ones, and this takes priority over every other input.
- R2: With `adv_en` high and no accepted seed load, `dout` after the edge holds the next WIDTH bits of the serial sequence y(n) = y(n-ORDER) XOR y(n-TAP). `dout[WIDTH-1]` is the earliest bit and `dout[0]` the latest. Consecutive words continue the stream with no gap and no overlap.
- R3: With `rst`, `adv_en` and `seed_ld` all low, the state and `dout` keep their values.
- R4: With `seed_ld` high and a non-zero `seed_val`, the state takes `seed_val`. Bit i of the seed is the sequence bit i+1 positions before the next new bit, and bit 0 is the most recent. `dout` then shows `seed_val[WIDTH-1:0]`.
- R5: A seed load with `seed_val` all zero is refused. The state behaves as if `seed_ld` were low, so it holds, or it advances when `adv_en` is high. The all-zero lock-up state is never entered.
- R6: Priority is reset first, then an accepted seed load, then advance.
- R7: With ORDER=7, TAP=6 and WIDTH=1, the one-bit output repeats with a period of exactly 127 clocks after reset.
- R8: When WIDTH exceeds TAP (ORDER=7, TAP=6, WIDTH=7), the chained variant produces the same serial sequence as R2 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high; loads the reset seed |
| adv_en | input | 1 | Advance the sequence by one word |
| seed_ld | input | 1 | Load `seed_val` into the state if it is non-zero |
| seed_val | input | ORDER | Seed; bit 0 is the most recent sequence bit |
| dout | output | WIDTH | Newest WIDTH sequence bits, earliest in the MSB |

## Verification
A wrong feedback tap or a wrong state bit appears in `dout` at the first advance that reads it. Within at most ORDER/WIDTH words (four words by default), it appears as a word that differs from the serial reference model. The bench steps that model once per bit and compares every word, so an error in bit order, in shift distance or in the tap shows up at the first affected edge. A lock-up or a shortened period shows only in the long run, so the 7-bit configuration is run for two full periods and its output is compared with itself one period later.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

   // state update selected for the next edge, highest priority last
   typedef enum logic [1:0] {
      UPD_HOLD = 2'd0,
      UPD_STEP = 2'd1,
      UPD_SEED = 2'd2,
      UPD_INIT = 2'd3
   } upd_sel_e;

   // legal polynomial / word configuration
   function automatic bit cfg_ok(input int order, input int tap, input int width);
      return (order >= 2) && (tap >= 1) && (tap < order) &&
             (width >= 1) && (width <= order);
   endfunction

endpackage

// File: rtl/prbs_seed_guard.sv
module prbs_seed_guard
   import prbs_pkg::*;
#(
   parameter int ORDER = 31
) (
   input  logic             rst,
   input  logic             adv_en,
   input  logic             seed_ld,
   input  logic [ORDER-1:0] seed_val,
   output upd_sel_e         sel
);

   logic seed_nonzero;

   assign seed_nonzero = |seed_val;

   always_comb begin
      if (rst)
         sel = UPD_INIT;
      else if (seed_ld && seed_nonzero)
         sel = UPD_SEED;
      else if (adv_en)
         sel = UPD_STEP;
      else
         sel = UPD_HOLD;
   end

endmodule

// File: rtl/prbs_lookahead.sv
module prbs_lookahead #(
   parameter int ORDER = 31,
   parameter int TAP   = 28,
   parameter int WIDTH = 10
) (
   input  logic [ORDER-1:0] cur,
   output logic [ORDER-1:0] nxt
);

   // cur[i] is the sequence bit i+1 positions before the next new bit
   localparam bit DIRECT = (WIDTH <= TAP);
   localparam int KEEP   = ORDER - WIDTH;

   generate
      if (DIRECT) begin : g_direct
         // every new bit reads only held bits: one XOR level
         for (genvar j = 0; j < WIDTH; j++) begin : g_term
            assign nxt[WIDTH-1-j] = cur[ORDER-1-j] ^ cur[TAP-1-j];
         end
         if (KEEP > 0) begin : g_keep
            assign nxt[ORDER-1:WIDTH] = cur[KEEP-1:0];
         end
      end else begin : g_chain
         // later bits reuse bits generated earlier in the same word
         function automatic logic [ORDER-1:0] walk(input logic [ORDER-1:0] s);
            logic [ORDER-1:0] t;
            logic             b;
            t = s;
            for (int k = 0; k < WIDTH; k++) begin
               b = t[ORDER-1] ^ t[TAP-1];
               t = {t[ORDER-2:0], b};
            end
            return t;
         endfunction

         assign nxt = walk(cur);
      end
   endgenerate

endmodule

// File: rtl/prbs_state_reg.sv
module prbs_state_reg
   import prbs_pkg::*;
#(
   parameter int               ORDER    = 31,
   parameter logic [ORDER-1:0] RST_SEED = '1
) (
   input  logic             clk,
   input  upd_sel_e         sel,
   input  logic [ORDER-1:0] step_val,
   input  logic [ORDER-1:0] seed_val,
   output logic [ORDER-1:0] st_q
);

   always_ff @(posedge clk) begin
      unique case (sel)
         UPD_INIT: st_q <= RST_SEED;
         UPD_SEED: st_q <= seed_val;
         UPD_STEP: st_q <= step_val;
         default:  st_q <= st_q;
      endcase
   end

endmodule

// File: rtl/prbs_par_gen.sv
module prbs_par_gen
   import prbs_pkg::*;
#(
   parameter int               ORDER    = 31,
   parameter int               TAP      = 28,
   parameter int               WIDTH    = 10,
   parameter logic [ORDER-1:0] RST_SEED = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv_en,
   input  logic             seed_ld,
   input  logic [ORDER-1:0] seed_val,
   output logic [WIDTH-1:0] dout
);

   generate
      if (!cfg_ok(ORDER, TAP, WIDTH)) begin : g_bad_cfg
         $error("prbs_par_gen: need 1 <= TAP < ORDER and 1 <= WIDTH <= ORDER");
      end
      if (RST_SEED == '0) begin : g_bad_seed
         $error("prbs_par_gen: reset seed must be non-zero");
      end
   endgenerate

   upd_sel_e         sel;
   logic [ORDER-1:0] step_val;
   logic [ORDER-1:0] st_q;

   prbs_seed_guard #(.ORDER(ORDER)) guard_i (
      .rst      (rst),
      .adv_en   (adv_en),
      .seed_ld  (seed_ld),
      .seed_val (seed_val),
      .sel      (sel)
   );

   prbs_lookahead #(.ORDER(ORDER), .TAP(TAP), .WIDTH(WIDTH)) la_i (
      .cur (st_q),
      .nxt (step_val)
   );

   prbs_state_reg #(.ORDER(ORDER), .RST_SEED(RST_SEED)) reg_i (
      .clk      (clk),
      .sel      (sel),
      .step_val (step_val),
      .seed_val (seed_val),
      .st_q     (st_q)
   );

   // newest WIDTH bits straight from flops, earliest in the MSB
   assign dout = st_q[WIDTH-1:0];

endmodule

// File: rtl/prbs_par_gen_chk.sv
module prbs_par_gen_chk #(
   parameter int               ORDER    = 31,
   parameter int               WIDTH    = 10,
   parameter logic [ORDER-1:0] RST_SEED = '1
) (
   input logic             clk,
   input logic             rst,
   input logic             adv_en,
   input logic             seed_ld,
   input logic [ORDER-1:0] seed_val,
   input logic [ORDER-1:0] st_q,
   input logic [WIDTH-1:0] dout
);

   localparam int KEEP = ORDER - WIDTH;

   // R1: reset loads the reset seed
   a_r1_reset_seed: assert property (@(posedge clk)
      rst |=> (st_q == RST_SEED));

   // R3: idle inputs hold the output word
   a_r3_hold: assert property (@(posedge clk) disable iff (rst)
      (!adv_en && !seed_ld) |=> $stable(dout));

   // R4: accepted seed appears on the output
   a_r4_seed_out: assert property (@(posedge clk) disable iff (rst)
      (seed_ld && (seed_val != '0)) |=> (dout == $past(seed_val[WIDTH-1:0])));

   // R5: zero seed without advance changes nothing
   a_r5_zero_refused: assert property (@(posedge clk) disable iff (rst)
      (seed_ld && (seed_val == '0) && !adv_en) |=> $stable(st_q));

   // R5: lock-up state never reached after reset
   a_r5_never_zero: assert property (@(posedge clk) disable iff (rst)
      $past(rst) || !$past(rst) |-> (st_q != '0));

   // R6: reset wins over a simultaneous seed load
   a_r6_reset_first: assert property (@(posedge clk)
      (rst && seed_ld) |=> (st_q == RST_SEED));

   // R2: an advance ages every held bit by WIDTH positions
   generate
      if (KEEP > 0) begin : g_age
         a_r2_age: assert property (@(posedge clk) disable iff (rst)
            (adv_en && !seed_ld) |=> (st_q[ORDER-1:WIDTH] == $past(st_q[KEEP-1:0])));
      end
   endgenerate

endmodule

bind prbs_par_gen prbs_par_gen_chk #(
   .ORDER    (ORDER),
   .WIDTH    (WIDTH),
   .RST_SEED (RST_SEED)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .adv_en   (adv_en),
   .seed_ld  (seed_ld),
   .seed_val (seed_val),
   .st_q     (st_q),
   .dout     (dout)
);

// File: tb/prbs_par_gen_tb_top.sv
module prbs_par_gen_tb_top;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst    = 1'b1;
   logic        adv    = 1'b0;
   logic        ld     = 1'b0;
   logic [30:0] sv     = '0;
   logic [9:0]  dout;
   logic        adv_s  = 1'b0;
   logic [0:0]  d7;
   logic [6:0]  dc;

   prbs_par_gen dut_i (
      .clk(clk), .rst(rst), .adv_en(adv), .seed_ld(ld), .seed_val(sv), .dout(dout));

   prbs_par_gen #(.ORDER(7), .TAP(6), .WIDTH(1)) dut7_i (
      .clk(clk), .rst(rst), .adv_en(adv_s), .seed_ld(1'b0), .seed_val(7'd0), .dout(d7));

   prbs_par_gen #(.ORDER(7), .TAP(6), .WIDTH(7)) dutc_i (
      .clk(clk), .rst(rst), .adv_en(adv_s), .seed_ld(1'b0), .seed_val(7'd0), .dout(dc));

   int          checks = 0;
   int          errors = 0;
   bit          done   = 0;
   logic [63:0] m;
   logic [63:0] m7;
   logic [63:0] mc;
   logic [0:0]  hist [0:253];
   int unsigned rs;

   // one serial step: newest bit enters at bit 0
   function automatic logic [63:0] sstep(input logic [63:0] s, input int n, input int t);
      logic b;
      b = s[n-1] ^ s[t-1];
      s = (s << 1) | 64'(b);
      s = s & ((64'd1 << n) - 64'd1);
      return s;
   endfunction

   function automatic logic [63:0] nstep(input logic [63:0] s, input int n, input int t,
                                         input int k);
      for (int i = 0; i < k; i++) s = sstep(s, n, t);
      return s;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // drive one cycle, update model, sample 1 ns after the edge
   task automatic cyc(input logic r, input logic a, input logic l, input logic [30:0] s,
                      input string tag);
      rst = r; adv = a; ld = l; sv = s;
      if (r)                  m = 64'h7fff_ffff;
      else if (l && s != '0)  m = 64'(s);
      else if (a)             m = nstep(m, 31, 28, 10);
      @(posedge clk);
      #1;
      chk(tag, 64'(dout), 64'(m[9:0]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog act=running exp=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rs = $urandom(32'h5EED_0A11);
      m = '0;
      // R1: reset state
      cyc(1, 0, 0, '0, "R1");
      cyc(0, 0, 0, '0, "R3");
      // R5: zero seed refused while idle, then with advance
      cyc(0, 0, 1, '0, "R5");
      cyc(0, 1, 1, '0, "R5");
      // R2: plain advance from reset seed
      for (int i = 0; i < 8; i++) cyc(0, 1, 0, '0, "R2");
      // R4: sparse seed, then run out its pattern
      cyc(0, 0, 1, 31'h1, "R4");
      for (int i = 0; i < 6; i++) cyc(0, 1, 0, '0, "R2");
      // R6: load beats advance; reset beats load
      cyc(0, 1, 1, 31'h2AAA_5555, "R6");
      cyc(1, 1, 1, 31'h0123_4567, "R6");
      cyc(0, 0, 0, '0, "R3");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic r, a, l;
         logic [30:0] s;
         string tag;
         r = ($urandom_range(99) == 0);
         l = ($urandom_range(19) == 0);
         a = ($urandom_range(3) != 0);
         s = ($urandom_range(1) == 0) ? 31'd0 : 31'($urandom);
         if (r)               tag = "R1";
         else if (l && s != 0) tag = a ? "R6" : "R4";
         else if (l)           tag = "R5";
         else if (a)           tag = "R2";
         else                  tag = "R3";
         cyc(r, a, l, s, tag);
      end
      // small configurations
      rst = 1; adv = 0; ld = 0; sv = '0; adv_s = 0;
      @(posedge clk); #1;
      chk("R1", 64'(d7), 64'd1);
      chk("R1", 64'(dc), 64'h7f);
      m7 = 64'h7f; mc = 64'h7f;
      rst = 0; adv_s = 1;
      for (int k = 0; k < 254; k++) begin
         m7 = sstep(m7, 7, 6);
         mc = nstep(mc, 7, 6, 7);
         @(posedge clk); #1;
         chk("R8", 64'(dc), mc);
         chk("R7", 64'(d7), 64'(m7[0]));
         hist[k] = d7;
      end
      begin
         int mism, ones;
         mism = 0; ones = 0;
         for (int k = 0; k < 127; k++) begin
            if (hist[k] !== hist[k+127]) mism++;
            if (hist[k] == 1'b1) ones++;
         end
         chk("R7", 64'(mism), 64'd0);
         chk("R7", 64'(ones), 64'd64);
      end
      // main instance held through the whole phase
      chk("R3", 64'(dout), 64'h3ff);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule